// File: doc/BRIEF.md
# Cascadable LCD Column Data Loader

This block is the digital front end of one column-driver chip in a daisy chain. A line pulse puts the loader back to idle. It then ignores pixel traffic until the previous chip in the chain raises its enable. While selected, it accepts pixel data on a shift strobe, either as 8-bit words or as pairs of 4-bit nibbles, and assembles bytes from them. It stores the bytes into a 160-bit row buffer through a group pointer that advances every 16 bits. The pointer runs upward or downward, depending on a direction input.

After the twentieth byte, the loader deselects itself and raises a cascade enable. That enable hands the shared data bus to the next chip, and it stays high until the next line pulse. When the line pulse falls, the whole row buffer is copied into a display register at once. Each display register bit is turned into a 2-bit drive-level select. The select depends on the pixel value, the frame-polarity input and a blanking input. Level shifting and the analog drivers sit outside this block.

Top module: `seg_loader_top`

## Requirements
- R1: While `lp_i` is high at a clock edge, the loader returns to idle, `eout_o` goes low on that edge, and any half-assembled nibble pair is discarded.
- R2: In idle, shift strobes change nothing. A select happens only on a clock edge where `ein_i` is high and `lp_i` is low, and the first accepted strobe is the one on the following edge.
- R3: With `wide_i` high, each accepted strobe writes `data_i[7:0]` as one byte.
- R4: With `wide_i` low, two accepted strobes form one byte. The `data_i[3:0]` of the first strobe becomes bits 7:4 and that of the second becomes bits 3:0; `data_i[7:4]` is ignored.
- R5: Byte k (0..19) of a row goes to byte slot s of group g, with g = k/2 and s = k%2. Group g occupies row bits [16*p+8*s+7 : 16*p+8*s], where p = g when `dir_i` was low at select and p = 9-g when it was high. Data bit j lands on row bit 16*p+8*s+j.
- R6: `eout_o` rises on the edge that writes the twentieth byte and holds until the next line pulse. After that, further strobes write nothing, and no more than 20 bytes are written per line.
- R7: On the first clock edge with `lp_i` low after an edge with it high, the whole row buffer is copied to the display register. At all other times the display register holds.
- R8: `seg_o[2i+1:2i]` encodes row bit i with codes V0=00, V12=01, V43=10, V5=11. For `fr_i` low, a pixel at 1 gives V0 and a pixel at 0 gives V43. For `fr_i` high, a pixel at 1 gives V5 and a pixel at 0 gives V12.
- R9: While `dispoff_i` is high, every output carries the pixel-0 code of the current frame polarity (V43 when `fr_i` is low, V12 when it is high).
- R10: After reset, `eout_o` is low and the display register is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shift clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lp_i | input | 1 | Line pulse: high resets the loader, falling edge transfers the row |
| ein_i | input | 1 | Enable from the previous chip in the chain |
| dir_i | input | 1 | Group pointer direction (0 up, 1 down), sampled at select |
| wide_i | input | 1 | 1 for 8-bit input, 0 for 4-bit nibble pairs |
| shift_i | input | 1 | Data strobe, one transfer per clock edge |
| data_i | input | 8 | Pixel data |
| fr_i | input | 1 | Frame polarity |
| dispoff_i | input | 1 | Blank all outputs |
| eout_o | output | 1 | Cascade enable to the next chip |
| seg_o | output | 320 | Two-bit drive-level select for each of the 160 columns |

## Verification
On every cycle, the assertions check the following:
- the line pulse clears the cascade enable;
- the enable holds until the next line pulse;
- the byte count never passes twenty, and the enable rises only at exactly twenty;
- no write happens outside the load phase;
- the outputs hold between transfers;
- blanking forces the pixel-0 level.

Some behaviours only the bench scenarios can show. These are the exact bit placement for both pointer directions, the nibble ordering, the discarding of a partial nibble pair, and that strobes before select or after the twentieth byte leave the transferred row unchanged. The bench shows them by comparing full rows against its own model.

// File: rtl/seg_ldr_pkg.sv
package seg_ldr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_DONE = 2'd2
  } ldr_state_e;

  localparam logic [1:0] LVL_V0  = 2'b00;
  localparam logic [1:0] LVL_V12 = 2'b01;
  localparam logic [1:0] LVL_V43 = 2'b10;
  localparam logic [1:0] LVL_V5  = 2'b11;

  function automatic logic [1:0] drv_level(input logic pix, input logic fr, input logic blank);
    logic on;
    on = pix & ~blank;
    if (fr) return on ? LVL_V5 : LVL_V12;
    else    return on ? LVL_V0 : LVL_V43;
  endfunction
endpackage

// File: rtl/seg_packer.sv
module seg_packer #(
  parameter int BUS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             act_i,
  input  logic             shift_i,
  input  logic             wide_i,
  input  logic [BUS_W-1:0] data_i,
  output logic             byte_vld_o,
  output logic [BUS_W-1:0] byte_o
);
  localparam int HALF = BUS_W / 2;

  logic            phase_q;
  logic [HALF-1:0] half_q;
  logic            take;

  assign take = act_i & shift_i;

  always_comb begin
    byte_vld_o = take & (wide_i | phase_q);
    byte_o     = wide_i ? data_i : {half_q, data_i[HALF-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      half_q  <= '0;
    end else if (clr_i) begin
      phase_q <= 1'b0;
    end else if (take && !wide_i) begin
      phase_q <= ~phase_q;
      if (!phase_q) half_q <= data_i[HALF-1:0];
    end
  end
endmodule

// File: rtl/seg_fill_ctrl.sv
module seg_fill_ctrl
  import seg_ldr_pkg::*;
#(
  parameter int NUM_BYTES       = 20,
  parameter int NUM_GROUPS      = 10,
  parameter int BYTES_PER_GROUP = 2,
  localparam int SELW           = $clog2(NUM_BYTES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lp_i,
  input  logic            ein_i,
  input  logic            dir_i,
  input  logic            byte_vld_i,
  output logic            act_o,
  output logic            eout_o,
  output logic [SELW-1:0] byte_sel_o
);
  localparam int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam int SW = (BYTES_PER_GROUP > 1) ? $clog2(BYTES_PER_GROUP) : 1;
  localparam int CW = $clog2(NUM_BYTES);

  ldr_state_e    state_q;
  logic          dir_q;
  logic [GW-1:0] grp_q;
  logic [SW-1:0] sub_q;
  logic [CW-1:0] cnt_q;
  logic          wr;

  assign act_o      = (state_q == ST_LOAD);
  assign eout_o     = (state_q == ST_DONE);
  assign wr         = act_o & byte_vld_i;
  assign byte_sel_o = SELW'(grp_q) * SELW'(BYTES_PER_GROUP) + SELW'(sub_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b0;
      grp_q   <= '0;
      sub_q   <= '0;
      cnt_q   <= '0;
    end else if (lp_i) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (ein_i) begin
          state_q <= ST_LOAD;
          dir_q   <= dir_i;
          grp_q   <= dir_i ? GW'(NUM_GROUPS - 1) : '0;
          sub_q   <= '0;
          cnt_q   <= '0;
        end
        ST_LOAD: if (wr) begin
          cnt_q <= cnt_q + 1'b1;
          if (sub_q == SW'(BYTES_PER_GROUP - 1)) begin
            sub_q <= '0;
            grp_q <= dir_q ? grp_q - 1'b1 : grp_q + 1'b1;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
          if (cnt_q == CW'(NUM_BYTES - 1)) state_q <= ST_DONE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/seg_row_latch.sv
module seg_row_latch #(
  parameter int ROW_BITS = 160,
  parameter int BUS_W    = 8,
  localparam int NUM_BYTES = ROW_BITS / BUS_W,
  localparam int SELW      = $clog2(NUM_BYTES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [SELW-1:0]     sel_i,
  input  logic [BUS_W-1:0]    byte_i,
  input  logic                xfer_i,
  output logic [ROW_BITS-1:0] line_o
);
  logic [ROW_BITS-1:0] data_q;
  logic [ROW_BITS-1:0] line_q;

  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          data_q[k*BUS_W +: BUS_W] <= '0;
      else if (we_i && sel_i == SELW'(k))   data_q[k*BUS_W +: BUS_W] <= byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     line_q <= '0;
    else if (xfer_i) line_q <= data_q;
  end

  assign line_o = line_q;
endmodule

// File: rtl/seg_level_enc.sv
module seg_level_enc
  import seg_ldr_pkg::*;
#(
  parameter int ROW_BITS = 160
) (
  input  logic [ROW_BITS-1:0]   line_i,
  input  logic                  fr_i,
  input  logic                  dispoff_i,
  output logic [2*ROW_BITS-1:0] seg_o
);
  for (genvar i = 0; i < ROW_BITS; i++) begin : g_col
    assign seg_o[2*i +: 2] = drv_level(line_i[i], fr_i, dispoff_i);
  end
endmodule

// File: rtl/seg_loader_top.sv
module seg_loader_top #(
  parameter int ROW_BITS   = 160,
  parameter int BUS_W      = 8,
  parameter int GROUP_BITS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  lp_i,
  input  logic                  ein_i,
  input  logic                  dir_i,
  input  logic                  wide_i,
  input  logic                  shift_i,
  input  logic [BUS_W-1:0]      data_i,
  input  logic                  fr_i,
  input  logic                  dispoff_i,
  output logic                  eout_o,
  output logic [2*ROW_BITS-1:0] seg_o
);
  localparam int NUM_BYTES  = ROW_BITS / BUS_W;
  localparam int NUM_GROUPS = ROW_BITS / GROUP_BITS;
  localparam int BPG        = GROUP_BITS / BUS_W;
  localparam int SELW       = $clog2(NUM_BYTES);

  logic             lp_q;
  logic             xfer;
  logic             act;
  logic             byte_vld;
  logic [BUS_W-1:0] byte_d;
  logic [SELW-1:0]  byte_sel;
  logic [ROW_BITS-1:0] line;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lp_q <= 1'b0;
    else         lp_q <= lp_i;
  end
  assign xfer = lp_q & ~lp_i;

  seg_packer #(.BUS_W(BUS_W)) u_pack (
    .clk_i, .rst_ni, .clr_i(lp_i), .act_i(act), .shift_i, .wide_i, .data_i,
    .byte_vld_o(byte_vld), .byte_o(byte_d)
  );

  seg_fill_ctrl #(
    .NUM_BYTES(NUM_BYTES), .NUM_GROUPS(NUM_GROUPS), .BYTES_PER_GROUP(BPG)
  ) u_fill (
    .clk_i, .rst_ni, .lp_i, .ein_i, .dir_i, .byte_vld_i(byte_vld),
    .act_o(act), .eout_o, .byte_sel_o(byte_sel)
  );

  seg_row_latch #(.ROW_BITS(ROW_BITS), .BUS_W(BUS_W)) u_row (
    .clk_i, .rst_ni, .we_i(byte_vld), .sel_i(byte_sel), .byte_i(byte_d),
    .xfer_i(xfer), .line_o(line)
  );

  seg_level_enc #(.ROW_BITS(ROW_BITS)) u_enc (
    .line_i(line), .fr_i, .dispoff_i, .seg_o
  );
endmodule

// File: rtl/seg_loader_chk.sv
module seg_loader_chk #(
  parameter int ROW_BITS  = 160,
  parameter int NUM_BYTES = 20
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  lp_i,
  input logic                  fr_i,
  input logic                  dispoff_i,
  input logic                  eout_o,
  input logic [2*ROW_BITS-1:0] seg_o,
  input logic                  wr_en,
  input logic                  act
);
  localparam int CW = $clog2(NUM_BYTES + 2);

  logic [CW-1:0] wcnt_q;
  logic          lp_d;
  logic          fell_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      lp_d   <= 1'b0;
      fell_q <= 1'b0;
    end else begin
      lp_d   <= lp_i;
      fell_q <= lp_d & ~lp_i;
      if (lp_i)       wcnt_q <= '0;
      else if (wr_en) wcnt_q <= wcnt_q + 1'b1;
    end
  end

  assert_lp_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_i |=> (!eout_o && !act));

  assert_idle_no_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act) |-> !wr_en);

  assert_byte_budget_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcnt_q <= CW'(NUM_BYTES));

  assert_eout_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eout_o) |-> (wcnt_q == CW'(NUM_BYTES)));

  assert_eout_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eout_o && !lp_i) |=> eout_o);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fell_q && $stable(fr_i) && $stable(dispoff_i)) |-> $stable(seg_o));

  assert_blank_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dispoff_i |-> (seg_o == {ROW_BITS{fr_i ? 2'b01 : 2'b10}}));
endmodule

bind seg_loader_top seg_loader_chk #(.ROW_BITS(ROW_BITS), .NUM_BYTES(NUM_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lp_i(lp_i), .fr_i(fr_i), .dispoff_i(dispoff_i),
  .eout_o(eout_o), .seg_o(seg_o), .wr_en(byte_vld), .act(act)
);

// File: tb/seg_loader_top_tb.sv
`timescale 1ns/1ps
module seg_loader_top_tb;
  localparam int RB = 160;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          lp_i = 1'b0, ein_i = 1'b0, dir_i = 1'b0, wide_i = 1'b1, shift_i = 1'b0;
  logic [7:0]    data_i = '0;
  logic          fr_i = 1'b0, dispoff_i = 1'b0;
  logic          eout_o;
  logic [2*RB-1:0] seg_o;

  int total = 0;
  int bad = 0;
  logic [RB-1:0] row_a, row_b, row_c, row_r;

  always #4 clk = ~clk;

  seg_loader_top u_dut (
    .clk_i(clk), .rst_ni, .lp_i, .ein_i, .dir_i, .wide_i, .shift_i, .data_i,
    .fr_i, .dispoff_i, .eout_o, .seg_o
  );

  function automatic logic [2*RB-1:0] exp_seg(input logic [RB-1:0] row, input logic fr, input logic off);
    logic [2*RB-1:0] v;
    for (int i = 0; i < RB; i++) begin
      if (off || !row[i]) v[2*i +: 2] = fr ? 2'b01 : 2'b10;
      else                v[2*i +: 2] = fr ? 2'b11 : 2'b00;
    end
    return v;
  endfunction

  function automatic int slot_base(input int k, input logic dir);
    int g;
    g = k / 2;
    if (dir) g = 9 - g;
    return g * 16 + (k % 2) * 8;
  endfunction

  task automatic chk_bit(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic chk_seg(input string req, input logic [RB-1:0] row);
    logic [2*RB-1:0] e;
    e = exp_seg(row, fr_i, dispoff_i);
    total++;
    if (seg_o !== e) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, seg_o, e);
    end
  endtask

  task automatic strobe(input logic [7:0] d);
    @(negedge clk);
    shift_i = 1'b1;
    data_i  = d;
    @(negedge clk);
    shift_i = 1'b0;
  endtask

  task automatic line_pulse();
    @(negedge clk);
    lp_i = 1'b1;
    @(negedge clk);
    lp_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic select(input logic dir);
    @(negedge clk);
    dir_i = dir;
    ein_i = 1'b1;
    @(negedge clk);
    ein_i = 1'b0;
  endtask

  // loads 20 random bytes, checks cascade enable timing (R6)
  task automatic load_row(input logic wide, input logic dir, output logic [RB-1:0] row);
    logic [7:0] b;
    int base;
    row = '0;
    wide_i = wide;
    for (int k = 0; k < 20; k++) begin
      b = 8'($urandom);
      base = slot_base(k, dir);
      for (int j = 0; j < 8; j++) row[base + j] = b[j];
      if (k == 19) chk_bit("R6 eout low before last byte", eout_o, 1'b0);
      if (wide) begin
        strobe(b);
      end else begin
        strobe({4'($urandom), b[7:4]});
        strobe({4'($urandom), b[3:0]});
      end
    end
    chk_bit("R6 eout after 20th byte", eout_o, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7703));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_bit("R10 eout reset", eout_o, 1'b0);
    chk_seg("R10 R8 reset row", '0);

    // R2: strobes before select are ignored
    line_pulse();
    wide_i = 1'b1;
    repeat (3) strobe(8'hFF);
    chk_bit("R2 idle strobes", eout_o, 1'b0);
    select(1'b0);
    load_row(1'b1, 1'b0, row_a);
    repeat (4) strobe(8'($urandom));   // R6: ignored after done
    chk_bit("R6 eout holds", eout_o, 1'b1);
    line_pulse();
    chk_bit("R1 eout cleared", eout_o, 1'b0);
    chk_seg("R3 R5 R7 wide up row", row_a);
    fr_i = 1'b1;
    @(negedge clk);
    chk_seg("R8 frame high", row_a);
    dispoff_i = 1'b1;
    @(negedge clk);
    chk_seg("R9 blank fr high", row_a);
    fr_i = 1'b0;
    @(negedge clk);
    chk_seg("R9 blank fr low", row_a);
    dispoff_i = 1'b0;

    // R4/R5: nibble mode, downward pointer; R7 hold until pulse
    select(1'b1);
    load_row(1'b0, 1'b1, row_b);
    chk_seg("R7 hold before pulse", row_a);
    line_pulse();
    chk_seg("R4 R5 nibble down row", row_b);

    // R1: half nibble pair discarded by line pulse
    select(1'b0);
    wide_i = 1'b0;
    strobe(8'h0A);
    line_pulse();
    chk_seg("R1 partial pair no write", row_b);
    select(1'b0);
    load_row(1'b0, 1'b0, row_c);
    line_pulse();
    chk_seg("R4 R1 nibble phase fresh", row_c);

    // random rows
    for (int n = 0; n < 10; n++) begin
      logic w, d;
      w = 1'($urandom);
      d = 1'($urandom);
      if (n % 3 == 0) repeat (2) strobe(8'($urandom));  // R2 idle noise
      select(d);
      load_row(w, d, row_r);
      if (n % 2 == 1) strobe(8'($urandom));             // R6 post-done noise
      line_pulse();
      fr_i = 1'($urandom);
      dispoff_i = ($urandom % 4) == 0;
      @(negedge clk);
      chk_seg("R3 R4 R5 R8 R9 random row", row_r);
      dispoff_i = 1'b0;
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule